// File: doc/BRIEF.md
# Pattern-Triggered Serial Word Receiver

This block is a synchronous serial receiver. Its clock is the bit clock: while the enable input is high, every rising edge takes one sample of the serial data line. The receiver looks for a programmable start pattern. It compares a sliding window of the most recent samples with a compare value. After a match, an optional delay skips a programmed number of bit periods. The receiver then assembles data words of programmable length and bit order. Each word appears on a parallel output together with a one-cycle valid strobe.

The stop mode decides what happens after the start event. In counted mode, the receiver delivers a programmed number of words and then hunts for a fresh start pattern. In continuous mode, it delivers words back to back until a second pattern appears in the same sliding window. The word in progress is then completed and the receiver returns to hunting. All configuration comes in on static input ports. The controller has three named states. ST_HUNT waits for the start pattern. ST_DELAY skips the post-start bits. ST_DATA assembles words. The transitions are:
- HUNT to DELAY on a start match with a non-zero delay.
- HUNT to DATA on a start match with a zero delay.
- DELAY to DATA when the delay count runs out.
- DATA to HUNT when a counted frame completes, or when a continuous frame has seen its stop match.
- Any state to HUNT whenever enable is low.

Top module: `srx_pattern_rx`

## Requirements
- R1: While rst_n or en is low, word_valid is 0, word_data is 0, the controller is in ST_HUNT, and the sample history and the assembled partial word are cleared.
- R2: In ST_HUNT, a start match occurs on a sample when the last N samples (the current one is the newest, in bit 0 of the window) equal the low N bits of cfg_cmp0, where N = cfg_cmp_len in 1..16. A match also needs at least N samples taken since enable went high or since ST_HUNT was last entered.
- R3: cfg_cmp_len = 0 disables the start pattern: the receiver stays in ST_HUNT and emits no word.
- R4: After the start-match sample, the next cfg_delay samples (0..255) are ignored. The sample after them is the first data bit.
- R5: A word holds cfg_wlen+1 bits (1..32). It is zero-extended and right-aligned. word_valid pulses for one cycle, in the cycle that follows the clock edge that sampled the word's last bit.
- R6: With cfg_msb_first = 1, the first data bit of a word is its bit cfg_wlen (the MSB). With cfg_msb_first = 0, the first data bit is bit 0.
- R7: In counted mode (cfg_stop_cont = 0), cfg_wcnt+1 words are delivered per start event. The receiver then returns to ST_HUNT and needs a fresh start match made of N new samples.
- R8: In continuous mode (cfg_stop_cont = 1), words follow back to back and cfg_wcnt is not used. A data-phase sample whose last N samples equal the low N bits of cfg_cmp1 ends reception once the current word completes, including a word whose last bit made the match.
- R9: Dropping en in the middle of a word discards the partial word. No word is emitted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one sample per rising edge while enabled |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; low forces idle and clears history |
| sdata | input | 1 | Serial data line |
| cfg_cmp_len | input | 5 | Pattern length N (0 disables, 1..16) |
| cfg_cmp0 | input | 16 | Start pattern (low N bits used) |
| cfg_cmp1 | input | 16 | Stop pattern for continuous mode (low N bits used) |
| cfg_stop_cont | input | 1 | 0 = counted frames, 1 = continuous until stop pattern |
| cfg_delay | input | 8 | Bits ignored after the start match |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_wcnt | input | 8 | Words per start event minus one (counted mode) |
| cfg_msb_first | input | 1 | 1 = first bit is MSB, 0 = first bit is LSB |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 32 | Last completed word, zero-extended |

## Verification
A word is due in the cycle after the rising edge that samples its last bit. That edge comes exactly N + cfg_delay + k·(cfg_wlen+1) samples after the first pattern bit, where k counts the words. The bench drives every bit on the falling edge, and the posedge that follows takes the sample. A monitor on the falling edge sees each strobe half a cycle after it rises and pops the word from the expected queue. A strobe that arrives with an empty queue is a failure. So is a queue that still holds words after a run of idle bits. Together these catch words that come early, late or extra, as well as words that never come.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DELAY = 2'd1,
        ST_DATA  = 2'd2
    } srx_state_e;
endpackage

// File: rtl/srx_window.sv
module srx_window #(
    parameter int CMP_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_in,
    input  logic             clear_fill,
    input  logic [LEN_W-1:0] cmp_len,
    input  logic [CMP_W-1:0] cmp0,
    input  logic [CMP_W-1:0] cmp1,
    output logic             hit0,
    output logic             hit1
);
    logic [CMP_W-1:0] hist, win, mask;
    logic [LEN_W-1:0] fill, fill_inc;
    logic             armed;
    logic [1:0]       hits;

    assign win      = {hist[CMP_W-2:0], bit_in};
    assign fill_inc = (fill >= LEN_W'(CMP_W)) ? fill : fill + 1'b1;
    assign armed    = (cmp_len != '0) && (fill_inc >= cmp_len);

    always_comb begin
        for (int i = 0; i < CMP_W; i++) begin
            mask[i] = (LEN_W'(i) < cmp_len);
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_cmp
        logic [CMP_W-1:0] ref_val;
        assign ref_val = (g == 0) ? cmp0 : cmp1;
        assign hits[g] = armed && (((win ^ ref_val) & mask) == '0);
    end

    assign hit0 = hits[0];
    assign hit1 = hits[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            fill <= '0;
        end else if (!en) begin
            hist <= '0;
            fill <= '0;
        end else begin
            hist <= win;
            fill <= clear_fill ? '0 : fill_inc;
        end
    end
endmodule

// File: rtl/srx_assemble.sv
module srx_assemble #(
    parameter int WORD_W = 32,
    parameter int WLEN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              take,
    input  logic              bit_in,
    input  logic              msb_first,
    input  logic [WLEN_W-1:0] wlen,
    output logic              last,
    output logic [WORD_W-1:0] word
);
    logic [WLEN_W-1:0] bitcnt;
    logic [WORD_W-1:0] acc, acc_next;

    always_comb begin
        if (msb_first) begin
            acc_next = {acc[WORD_W-2:0], bit_in};
        end else begin
            acc_next = acc | (WORD_W'(bit_in) << bitcnt);
        end
    end

    assign last = take && (bitcnt == wlen);
    assign word = acc_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            acc    <= '0;
        end else if (!en) begin
            bitcnt <= '0;
            acc    <= '0;
        end else if (take) begin
            if (last) begin
                bitcnt <= '0;
                acc    <= '0;
            end else begin
                bitcnt <= bitcnt + 1'b1;
                acc    <= acc_next;
            end
        end
    end
endmodule

// File: rtl/srx_pattern_rx.sv
module srx_pattern_rx #(
    parameter int CMP_W  = 16,
    parameter int WORD_W = 32,
    parameter int DLY_W  = 8,
    parameter int CNT_W  = 8,
    localparam int LEN_W  = $clog2(CMP_W + 1),
    localparam int WLEN_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sdata,
    input  logic [LEN_W-1:0]  cfg_cmp_len,
    input  logic [CMP_W-1:0]  cfg_cmp0,
    input  logic [CMP_W-1:0]  cfg_cmp1,
    input  logic              cfg_stop_cont,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [WLEN_W-1:0] cfg_wlen,
    input  logic [CNT_W-1:0]  cfg_wcnt,
    input  logic              cfg_msb_first,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    import srx_pkg::*;

    srx_state_e        state, nstate;
    logic [DLY_W-1:0]  dcnt;
    logic [CNT_W-1:0]  wcnt;
    logic              stop_pend;
    logic              hit0, hit1, clear_fill, take, last;
    logic [WORD_W-1:0] asm_word;

    srx_window #(.CMP_W(CMP_W), .LEN_W(LEN_W)) u_window (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_in(sdata),
        .clear_fill(clear_fill), .cmp_len(cfg_cmp_len),
        .cmp0(cfg_cmp0), .cmp1(cfg_cmp1), .hit0(hit0), .hit1(hit1)
    );

    srx_assemble #(.WORD_W(WORD_W), .WLEN_W(WLEN_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .en(en), .take(take), .bit_in(sdata),
        .msb_first(cfg_msb_first), .wlen(cfg_wlen), .last(last), .word(asm_word)
    );

    // next-state and control decode
    always_comb begin
        nstate     = state;
        clear_fill = 1'b0;
        take       = 1'b0;
        if (en) begin
            unique case (state)
                ST_HUNT: begin
                    if (hit0) begin
                        clear_fill = 1'b1;
                        nstate     = (cfg_delay == '0) ? ST_DATA : ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (dcnt == DLY_W'(1)) nstate = ST_DATA;
                end
                ST_DATA: begin
                    take = 1'b1;
                    if (last) begin
                        if (cfg_stop_cont ? (stop_pend || hit1) : (wcnt == cfg_wcnt)) begin
                            nstate     = ST_HUNT;
                            clear_fill = 1'b1;
                        end
                    end
                end
                default: nstate = ST_HUNT;
            endcase
        end else begin
            nstate = ST_HUNT;
        end
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            dcnt      <= '0;
            wcnt      <= '0;
            stop_pend <= 1'b0;
        end else if (!en) begin
            state     <= ST_HUNT;
            dcnt      <= '0;
            wcnt      <= '0;
            stop_pend <= 1'b0;
        end else begin
            state <= nstate;
            if (state == ST_HUNT && nstate == ST_DELAY) begin
                dcnt <= cfg_delay;
            end else if (state == ST_DELAY) begin
                dcnt <= dcnt - 1'b1;
            end
            if (take && last) begin
                wcnt <= (nstate == ST_HUNT || cfg_stop_cont) ? '0 : wcnt + 1'b1;
            end
            if (state != ST_DATA || (take && last)) begin
                stop_pend <= 1'b0;
            end else if (cfg_stop_cont && hit1) begin
                stop_pend <= 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else if (!en) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= take && last;
            if (take && last) word_data <= asm_word;
        end
    end
endmodule

// File: rtl/srx_pattern_rx_chk.sv
module srx_pattern_rx_chk #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5,
    parameter int DLY_W  = 8,
    parameter int WLEN_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic [LEN_W-1:0]    cfg_cmp_len,
    input logic [DLY_W-1:0]    cfg_delay,
    input logic [WLEN_W-1:0]   cfg_wlen,
    input logic                word_valid,
    input logic [WORD_W-1:0]   word_data,
    input srx_pkg::srx_state_e state,
    input logic                hit0
);
    import srx_pkg::*;

    logic [WORD_W-1:0] wmask;
    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            wmask[i] = (i <= int'(cfg_wlen));
        end
    end

    a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_HUNT && !word_valid && word_data == '0));

    a_r3_no_pattern_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cmp_len == '0 && state == ST_HUNT) |=> state == ST_HUNT);

    a_r4_delay_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_HUNT && hit0 && cfg_delay != '0) |=> state == ST_DELAY);

    a_r4_no_word_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |=> !word_valid);

    a_r5_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ((word_data & ~wmask) == '0));
endmodule

bind srx_pattern_rx srx_pattern_rx_chk #(
    .WORD_W(WORD_W), .LEN_W(LEN_W), .DLY_W(DLY_W), .WLEN_W(WLEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_cmp_len(cfg_cmp_len),
    .cfg_delay(cfg_delay), .cfg_wlen(cfg_wlen), .word_valid(word_valid),
    .word_data(word_data), .state(state), .hit0(hit0)
);

// File: tb/srx_pattern_rx_tb.sv
`timescale 1ns/1ps
module srx_pattern_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        sdata = 1'b0;
    logic [4:0]  cfg_cmp_len = '0;
    logic [15:0] cfg_cmp0 = '0;
    logic [15:0] cfg_cmp1 = '0;
    logic        cfg_stop_cont = 1'b0;
    logic [7:0]  cfg_delay = '0;
    logic [4:0]  cfg_wlen = '0;
    logic [7:0]  cfg_wcnt = '0;
    logic        cfg_msb_first = 1'b1;
    logic        word_valid;
    logic [31:0] word_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    srx_pattern_rx u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sdata(sdata),
        .cfg_cmp_len(cfg_cmp_len), .cfg_cmp0(cfg_cmp0), .cfg_cmp1(cfg_cmp1),
        .cfg_stop_cont(cfg_stop_cont), .cfg_delay(cfg_delay), .cfg_wlen(cfg_wlen),
        .cfg_wcnt(cfg_wcnt), .cfg_msb_first(cfg_msb_first),
        .word_valid(word_valid), .word_data(word_data)
    );

    task automatic expect_word(input logic [31:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [31:0] v, input int n, input bit msb);
        for (int i = 0; i < n; i++) begin
            sdata = msb ? v[n-1-i] : v[i];
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [4:0] len, input logic [15:0] c0, input logic [15:0] c1,
                         input bit cont, input logic [7:0] dly, input logic [4:0] wl,
                         input logic [7:0] wc, input bit msb);
        @(negedge clk);
        en = 1'b0;
        cfg_cmp_len = len; cfg_cmp0 = c0; cfg_cmp1 = c1; cfg_stop_cont = cont;
        cfg_delay = dly; cfg_wlen = wl; cfg_wcnt = wc; cfg_msb_first = msb;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic check_drained(input string tag);
        send(32'h0, 24, 1'b1);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d words missing, expected next %h", tag, exp_q.size(), exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // monitor: pops the scoreboard on each strobe
    always @(negedge clk) begin
        if (rst_n && word_valid && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected word: actual %h expected none", word_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (word_data !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, word_data, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (word_valid !== 1'b0) begin errors++; $display("FAIL R1 reset valid: actual %b expected 0", word_valid); end
        checks++;
        if (word_data !== 32'h0) begin errors++; $display("FAIL R1 reset data: actual %h expected 0", word_data); end
        rst_n = 1'b1;

        // R4 R5 R6 R7: MSB first, delay 2, two words
        setup(5'd8, 16'h00A5, 16'h0, 1'b0, 8'd2, 5'd7, 8'd1, 1'b1);
        expect_word(32'h3C, "R6 msb word0");
        expect_word(32'hC3, "R7 msb word1");
        send(32'h00A5, 8, 1'b1);
        send(32'h3, 2, 1'b1);
        send(32'h3C, 8, 1'b1);
        send(32'hC3, 8, 1'b1);
        check_drained("R7 counted frame");

        // R4 delay boundary 255, three words
        setup(5'd8, 16'h00A5, 16'h0, 1'b0, 8'd255, 5'd7, 8'd2, 1'b1);
        expect_word(32'h3C, "R4 delay255 w0");
        expect_word(32'hC3, "R4 delay255 w1");
        expect_word(32'h5A, "R4 delay255 w2");
        send(32'h00A5, 8, 1'b1);
        for (int i = 0; i < 255; i++) send(32'h1, 1, 1'b1);
        send(32'h3C, 8, 1'b1);
        send(32'hC3, 8, 1'b1);
        send(32'h5A, 8, 1'b1);
        check_drained("R4 delay255");

        // R6 LSB first, 5-bit words, no delay
        setup(5'd4, 16'h000B, 16'h0, 1'b0, 8'd0, 5'd4, 8'd1, 1'b0);
        expect_word(32'h13, "R6 lsb word0");
        expect_word(32'h0C, "R6 lsb word1");
        send(32'hB, 4, 1'b1);
        send(32'h13, 5, 1'b0);
        send(32'h0C, 5, 1'b0);
        check_drained("R6 lsb frame");

        // R5 full 32-bit word, 16-bit pattern
        setup(5'd16, 16'hF00F, 16'h0, 1'b0, 8'd3, 5'd31, 8'd0, 1'b0);
        expect_word(32'hDEADBEEF, "R5 wide word");
        send(32'hF00F, 16, 1'b1);
        send(32'h5, 3, 1'b1);
        send(32'hDEADBEEF, 32, 1'b0);
        check_drained("R5 wide");

        // R2: pattern of zeros needs N samples after enable
        setup(5'd4, 16'h0000, 16'h0, 1'b0, 8'd0, 5'd3, 8'd0, 1'b1);
        expect_word(32'hA, "R2 fill guard");
        send(32'h0, 4, 1'b1);
        send(32'hA, 4, 1'b1);
        sdata = 1'b1;
        send(32'hFFFFFF, 24, 1'b1);
        checks++;
        if (exp_q.size() != 0) begin errors++; $display("FAIL R2 fill guard: %0d missing, expected %h", exp_q.size(), exp_q[0]); exp_q.delete(); tag_q.delete(); end

        // R7: fresh match required after a counted frame
        setup(5'd4, 16'h000A, 16'h0, 1'b0, 8'd0, 5'd7, 8'd0, 1'b1);
        expect_word(32'h05, "R7 first frame");
        send(32'hA, 4, 1'b1);
        send(32'h05, 8, 1'b1);
        send(32'h0, 12, 1'b1);
        checks++;
        if (exp_q.size() != 0) begin errors++; $display("FAIL R7 first frame missing: expected %h", exp_q[0]); exp_q.delete(); tag_q.delete(); end
        expect_word(32'h7E, "R7 rearmed frame");
        send(32'hA, 4, 1'b1);
        send(32'h7E, 8, 1'b1);
        check_drained("R7 rearm");

        // R8: continuous, stop match on last bit of a word
        setup(5'd4, 16'h0009, 16'h0006, 1'b1, 8'd1, 5'd7, 8'd0, 1'b1);
        expect_word(32'hFF, "R8 cont w0");
        expect_word(32'h00, "R8 cont w1");
        expect_word(32'h06, "R8 cont stop-on-last");
        send(32'h9, 4, 1'b1);
        send(32'h1, 1, 1'b1);
        send(32'hFF, 8, 1'b1);
        send(32'h00, 8, 1'b1);
        send(32'h06, 8, 1'b1);
        send(32'hFFFF, 16, 1'b1);
        check_drained("R8 cont end");

        // R8: stop match in the middle of a word
        setup(5'd4, 16'h0009, 16'h0006, 1'b1, 8'd1, 5'd7, 8'd0, 1'b1);
        expect_word(32'h60, "R8 cont stop-mid");
        send(32'h9, 4, 1'b1);
        send(32'h1, 1, 1'b1);
        send(32'h60, 8, 1'b1);
        send(32'hFFFF, 16, 1'b1);
        check_drained("R8 mid stop");

        // R3: pattern length zero never starts
        setup(5'd0, 16'h0000, 16'h0, 1'b0, 8'd0, 5'd3, 8'd0, 1'b1);
        send(32'h0F0F00A5, 32, 1'b1);
        check_drained("R3 disabled");

        // R9 / R1: enable dropped mid-word
        setup(5'd4, 16'h000A, 16'h0, 1'b0, 8'd0, 5'd7, 8'd0, 1'b1);
        send(32'hA, 4, 1'b1);
        send(32'hF, 4, 1'b1);
        en = 1'b0;
        @(negedge clk);
        checks++;
        if (word_valid !== 1'b0 || word_data !== 32'h0) begin errors++; $display("FAIL R1 disabled: actual %b/%h expected 0/0", word_valid, word_data); end
        en = 1'b1;
        send(32'hF, 4, 1'b1);
        send(32'h0, 8, 1'b1);
        checks++;
        if (exp_q.size() != 0) begin errors++; $display("FAIL R9 queue: actual %0d expected 0", exp_q.size()); end
        expect_word(32'h81, "R9 after abort");
        send(32'hA, 4, 1'b1);
        send(32'h81, 8, 1'b1);
        check_drained("R9 recover");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule